// File: doc/BRIEF.md
# Change-Detection Frame Sequencer

This block sequences a frame-based change-detection pipeline. Each frame start selects one of three modes. In Process, the pipeline takes in a frame and compares it with the stored previous one. In Display, the stored results go to the output encoder. In Idle, nothing happens. The mode changes only on a frame-start strobe. Processing stops for the rest of a one-second window of incoming frames once the requested number of frames has been processed in that window.

The same block generates the word address used by the previous-frame buffer and the result buffer. Both buffers are the same size and use the same layout. Each word holds two pixels. The address combines a field bit, a line number and a word column, so interlaced video can be stored field by field, with the odd field first. The block also drives the access strobes for both buffers.

Top module: `chgdet_frame_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `state_o` is 0 (Idle), every enable and access output is low, and `mem_addr_o` is 0.
- R2: `state_o` encodes Idle=0, Process=1 and Display=2. It changes only at a clock edge where `frame_sync_i` is high.
- R3: At a frame sync in Idle, the state becomes Process if the count of frames processed so far in the current window is below the effective rate. Otherwise it stays Idle.
- R4: Process moves to Display at a frame sync only if `proc_done_i` was high in some cycle since the previous sync, or is high in the sync cycle itself. Otherwise it stays in Process. Display is never entered from Idle.
- R5: At a frame sync in Display with `disp_done_i` seen (same rule as R4), the state becomes Process if quota remains, and Idle if not. Without the done signal it stays in Display.
- R6: A window spans FPS frame syncs, and the first sync after reset opens a window. The count of entries into Process restarts at 0 at every window start. The effective rate is `rate_i` clamped to MAX_RATE, so a rate of 0 never processes.
- R7: `mem_addr_o` = {field at bit LINE_W+COL_W, line in the next LINE_W bits, word column in the low COL_W bits}. A frame sync clears the whole address, which selects field 0 (odd). A `field_sync_i` without a frame sync sets the field bit to 1 and clears the line and column.
- R8: A `word_stb_i` in Process or Display advances the column. After column COLS-1 the column returns to 0 and the line advances. After the last word of line LINES-1 the address holds. In Idle a strobe leaves the address unchanged.
- R9: `proc_en_o` is high in Process and `disp_en_o` is high in Display. `prev_acc_o` and `res_wr_o` equal `word_stb_i` in Process. `res_rd_o` equals `word_stb_i` in Display. Each of these is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | One-cycle strobe at the start of a frame |
| field_sync_i | input | 1 | One-cycle strobe at the start of the even field |
| word_stb_i | input | 1 | One two-pixel word transferred this cycle |
| rate_i | input | RATE_W | Requested frames per window |
| proc_done_i | input | 1 | Processing path has finished its frame |
| disp_done_i | input | 1 | Display path has finished its frame |
| state_o | output | 2 | Current mode: 0 Idle, 1 Process, 2 Display |
| proc_en_o | output | 1 | Processing path enable |
| disp_en_o | output | 1 | Display path enable |
| prev_acc_o | output | 1 | Previous-frame buffer access this cycle |
| res_wr_o | output | 1 | Result buffer write this cycle |
| res_rd_o | output | 1 | Result buffer read this cycle |
| mem_addr_o | output | 1+LINE_W+COL_W | Word address shared by both buffers |

## Verification
The bench builds the block with an 8-frame window, a rate ceiling of 3, and a field of 3 lines by 4 words, keeping the default 9-bit line and column fields. The short window lets several window boundaries pass within a few hundred cycles. It also leaves a ceiling of 3 below the four launches that alternating Process and Display allows in 8 frames, so the clamp shows in the count. The small field lets a frame run past its last word, so the address hold and the line wrap are both reached. The address still keeps its full 19-bit layout.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROC = 2'd1,
    ST_DISP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chgdet_rate_gate.sv
module chgdet_rate_gate #(
  parameter int FPS      = 30,
  parameter int MAX_RATE = 15,
  parameter int RATE_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              take_i,
  output logic              grant_o
);
  localparam int FC_W = (FPS > 1) ? $clog2(FPS) : 1;
  localparam logic [FC_W-1:0]   FC_LAST = FC_W'(FPS - 1);
  localparam logic [RATE_W-1:0] RATE_CAP = RATE_W'(MAX_RATE);

  logic [FC_W-1:0]   fcnt_q, fcnt_nxt;
  logic [RATE_W-1:0] pcnt_q, base, eff_rate;

  assign fcnt_nxt = (fcnt_q == FC_LAST) ? '0 : fcnt_q + 1'b1;
  assign base     = (fcnt_nxt == '0) ? '0 : pcnt_q;
  assign eff_rate = (rate_i > RATE_CAP) ? RATE_CAP : rate_i;
  assign grant_o  = base < eff_rate;

  // counter starts at the last slot so the first sync opens a window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= FC_LAST;
      pcnt_q <= '0;
    end else if (frame_sync_i) begin
      fcnt_q <= fcnt_nxt;
      pcnt_q <= base + RATE_W'(take_i);
    end
  end
endmodule

// File: rtl/chgdet_seq_fsm.sv
module chgdet_seq_fsm
  import chgdet_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_sync_i,
  input  logic       proc_done_i,
  input  logic       disp_done_i,
  input  logic       grant_i,
  output seq_state_e state_o,
  output logic       take_o
);
  seq_state_e state_q, state_d;
  logic pdone_q, ddone_q;

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    if (frame_sync_i) begin
      unique case (state_q)
        ST_IDLE: if (grant_i) begin
          state_d = ST_PROC;
          take_o  = 1'b1;
        end
        ST_PROC: if (pdone_q || proc_done_i) state_d = ST_DISP;
        ST_DISP: if (ddone_q || disp_done_i) begin
          if (grant_i) begin
            state_d = ST_PROC;
            take_o  = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pdone_q <= 1'b0;
      ddone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (frame_sync_i) begin
        pdone_q <= 1'b0;
        ddone_q <= 1'b0;
      end else begin
        pdone_q <= pdone_q | proc_done_i;
        ddone_q <= ddone_q | disp_done_i;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/chgdet_addr_gen.sv
module chgdet_addr_gen #(
  parameter int LINES  = 240,
  parameter int COLS   = 320,
  parameter int LINE_W = 9,
  parameter int COL_W  = 9
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_sync_i,
  input  logic                      field_sync_i,
  input  logic                      adv_i,
  output logic [LINE_W+COL_W:0]     addr_o
);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);

  logic              field_q;
  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= 1'b0;
      line_q  <= '0;
      col_q   <= '0;
    end else if (frame_sync_i || field_sync_i) begin
      field_q <= !frame_sync_i;  // odd field first
      line_q  <= '0;
      col_q   <= '0;
    end else if (adv_i) begin
      if (col_q != COL_LAST) begin
        col_q <= col_q + 1'b1;
      end else if (line_q != LINE_LAST) begin
        col_q  <= '0;
        line_q <= line_q + 1'b1;
      end
    end
  end

  assign addr_o = {field_q, line_q, col_q};
endmodule

// File: rtl/chgdet_frame_ctrl.sv
module chgdet_frame_ctrl
  import chgdet_pkg::*;
#(
  parameter int FPS      = 30,
  parameter int MAX_RATE = 15,
  parameter int RATE_W   = 5,
  parameter int LINES    = 240,
  parameter int COLS     = 320,
  parameter int LINE_W   = 9,
  parameter int COL_W    = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_sync_i,
  input  logic                   field_sync_i,
  input  logic                   word_stb_i,
  input  logic [RATE_W-1:0]      rate_i,
  input  logic                   proc_done_i,
  input  logic                   disp_done_i,
  output logic [1:0]             state_o,
  output logic                   proc_en_o,
  output logic                   disp_en_o,
  output logic                   prev_acc_o,
  output logic                   res_wr_o,
  output logic                   res_rd_o,
  output logic [LINE_W+COL_W:0]  mem_addr_o
);
  seq_state_e state;
  logic grant, take;

  chgdet_rate_gate #(.FPS(FPS), .MAX_RATE(MAX_RATE), .RATE_W(RATE_W)) u_gate (
    .clk_i, .rst_ni, .frame_sync_i, .rate_i,
    .take_i(take), .grant_o(grant)
  );

  chgdet_seq_fsm u_fsm (
    .clk_i, .rst_ni, .frame_sync_i, .proc_done_i, .disp_done_i,
    .grant_i(grant), .state_o(state), .take_o(take)
  );

  chgdet_addr_gen #(.LINES(LINES), .COLS(COLS), .LINE_W(LINE_W), .COL_W(COL_W)) u_addr (
    .clk_i, .rst_ni, .frame_sync_i, .field_sync_i,
    .adv_i(word_stb_i && (state != ST_IDLE)), .addr_o(mem_addr_o)
  );

  assign state_o    = state;
  assign proc_en_o  = (state == ST_PROC);
  assign disp_en_o  = (state == ST_DISP);
  assign prev_acc_o = proc_en_o && word_stb_i;
  assign res_wr_o   = proc_en_o && word_stb_i;
  assign res_rd_o   = disp_en_o && word_stb_i;
endmodule

// File: rtl/chgdet_frame_ctrl_chk.sv
module chgdet_frame_ctrl_chk #(
  parameter int RATE_W = 5,
  parameter int AW     = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_sync_i,
  input logic              field_sync_i,
  input logic              proc_done_i,
  input logic [RATE_W-1:0] rate_i,
  input logic [1:0]        state_o,
  input logic [AW-1:0]     mem_addr_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= 1'b0;
    else if (frame_sync_i) seen_q <= 1'b0;
    else if (proc_done_i)  seen_q <= 1'b1;
  end

  assert_state_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sync_i |=> $stable(state_o));

  assert_proc_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && frame_sync_i && !proc_done_i && !seen_q) |=> state_o == 2'd1);

  assert_no_idle_to_disp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) |=> state_o != 2'd2);

  assert_zero_rate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && rate_i == '0) |=> state_o != 2'd1);

  assert_frame_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> mem_addr_o == '0);

  assert_field_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_sync_i && !frame_sync_i) |=> mem_addr_o == {1'b1, {(AW-1){1'b0}}});

  assert_idle_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !frame_sync_i && !field_sync_i) |=> $stable(mem_addr_o));

  assert_legal_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);
endmodule

bind chgdet_frame_ctrl chgdet_frame_ctrl_chk #(.RATE_W(RATE_W), .AW(LINE_W+COL_W+1)) u_chk (.*);

// File: tb/chgdet_frame_ctrl_tb.sv
module chgdet_frame_ctrl_tb;
  localparam int FPS = 8, MAX_RATE = 3, RATE_W = 5;
  localparam int LINES = 3, COLS = 4, LINE_W = 9, COL_W = 9;
  localparam int AW = LINE_W + COL_W + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_sync = 0, field_sync = 0, word_stb = 0, pdone = 0, ddone = 0;
  logic [RATE_W-1:0] rate = '0;
  logic [1:0] state_o;
  logic proc_en_o, disp_en_o, prev_acc_o, res_wr_o, res_rd_o;
  logic [AW-1:0] mem_addr_o;

  always #2.5 clk = ~clk;

  chgdet_frame_ctrl #(.FPS(FPS), .MAX_RATE(MAX_RATE), .RATE_W(RATE_W), .LINES(LINES),
    .COLS(COLS), .LINE_W(LINE_W), .COL_W(COL_W)) u_dut (
    .clk_i(clk), .rst_ni, .frame_sync_i(frame_sync), .field_sync_i(field_sync),
    .word_stb_i(word_stb), .rate_i(rate), .proc_done_i(pdone), .disp_done_i(ddone),
    .state_o, .proc_en_o, .disp_en_o, .prev_acc_o, .res_wr_o, .res_rd_o, .mem_addr_o);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  int m_state, m_fcnt, m_pcnt, m_field, m_line, m_col;
  bit m_pd, m_dd;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_fcnt = FPS - 1; m_pcnt = 0;
      m_field = 0; m_line = 0; m_col = 0; m_pd = 0; m_dd = 0;
    end else if (frame_sync) begin
      int eff, base;
      bit can;
      eff = (rate > MAX_RATE) ? MAX_RATE : int'(rate);
      m_fcnt = (m_fcnt + 1) % FPS;
      base = (m_fcnt == 0) ? 0 : m_pcnt;
      can = base < eff;
      m_pcnt = base;
      if (m_state == 0) begin
        if (can) begin m_state = 1; m_pcnt++; end
      end else if (m_state == 1) begin
        if (m_pd || pdone) m_state = 2;
      end else if (m_dd || ddone) begin
        if (can) begin m_state = 1; m_pcnt++; end
        else m_state = 0;
      end
      m_pd = 0; m_dd = 0; m_field = 0; m_line = 0; m_col = 0;
    end else begin
      m_pd = m_pd | pdone;
      m_dd = m_dd | ddone;
      if (field_sync) begin
        m_field = 1; m_line = 0; m_col = 0;
      end else if (word_stb && m_state != 0) begin
        if (m_col < COLS - 1) m_col++;
        else if (m_line < LINES - 1) begin m_col = 0; m_line++; end
      end
    end
  end

  function automatic longint exp_addr(int f, int l, int c);
    return (longint'(f) << (LINE_W + COL_W)) | (longint'(l) << COL_W) | longint'(c);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edges
  initial forever begin
    @(negedge clk); #1;
    if (rst_ni && !finished) begin
      bit wp, wd;
      wp = word_stb && m_state == 1;
      wd = word_stb && m_state == 2;
      check("R2/R3/R4/R5/R6 state", state_o, m_state);
      check("R7/R8 address", mem_addr_o, exp_addr(m_field, m_line, m_col));
      check("R9 enables", {proc_en_o, disp_en_o, prev_acc_o, res_wr_o, res_rd_o},
            {m_state == 1, m_state == 2, wp, wp, wd});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; frame_sync = 0; field_sync = 0; word_stb = 0; pdone = 0; ddone = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  // one frame: sync, words, optional even field, optional done pulses
  task automatic run_frame(int words, bit pd, bit dd, bit fld, output bit entered);
    bit was_proc;
    was_proc = (state_o == 2'd1);
    @(negedge clk); frame_sync = 1;
    @(negedge clk); frame_sync = 0;
    entered = (state_o == 2'd1) && !was_proc;
    for (int i = 0; i < words; i++) begin
      word_stb = ($urandom % 3) != 0;
      if (fld && i == words / 2) field_sync = 1;
      if (pd && i == words - 1) pdone = 1;
      if (dd && i == words - 1) ddone = 1;
      @(negedge clk);
      word_stb = 0; field_sync = 0; pdone = 0; ddone = 0;
    end
  endtask

  task automatic count_run(int r, int frames, int exp, string tag);
    int cnt = 0;
    bit e;
    do_reset();
    rate = RATE_W'(r);
    for (int i = 0; i < frames; i++) begin
      run_frame(4, 1, 1, 0, e);
      cnt += e;
    end
    check(tag, cnt, exp);
  endtask

  initial begin
    bit e;
    do_reset();
    @(negedge clk); #1;
    check("R1 reset state", state_o, 0);
    check("R1 reset address", mem_addr_o, 0);
    check("R1 reset enables", {proc_en_o, disp_en_o, prev_acc_o, res_wr_o, res_rd_o}, 0);

    count_run(2, FPS, 2, "R3 rate 2 entries");
    count_run(3, FPS, 3, "R6 rate at ceiling");
    count_run(9, FPS, 3, "R6 rate clamped");
    count_run(0, FPS, 0, "R6 zero rate");
    count_run(2, 2 * FPS, 4, "R6 quota restart");
    count_run(1, FPS + 1, 2, "R5 new window launch");

    // R8 hold at end of field, R7 even field
    do_reset();
    rate = 3;
    run_frame(0, 0, 0, 0, e);
    check("R4 entered process", state_o, 1);
    word_stb = 1;
    repeat (LINES * COLS + 5) @(negedge clk);
    word_stb = 0;
    #1 check("R8 address hold", mem_addr_o, exp_addr(0, LINES - 1, COLS - 1));
    @(negedge clk); field_sync = 1;
    @(negedge clk); field_sync = 0;
    #1 check("R7 even field start", mem_addr_o, exp_addr(1, 0, 0));
    run_frame(3, 0, 0, 0, e);
    check("R4 no done stays process", state_o, 1);

    // random traffic against the model
    for (int i = 0; i < 300; i++) begin
      if (i % 40 == 0) rate = RATE_W'($urandom % 7);
      run_frame(2 + $urandom % 16, $urandom % 4 != 0, $urandom % 4 != 0, $urandom % 2, e);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule